// File: doc/BRIEF.md
# Refresh-Gated Master/Slave Delay-Lock Controller

This block is the control logic of a digital delay-lock loop inside a DRAM memory controller. It calibrates a master delay line by stepping its tap count upward from zero until a phase detector reports that the delayed reference edge has reached the next reference edge. The tap count found this way is the number of delay elements in one full clock period. Because every slave line is built from the same elements, that count is scaled by a per-lane 8-bit fraction (units of 1/256 cycle) to give each slave's tap setting. There is one slave per read strobe lane and one for the write data.

Calibration runs only while the refresh window is open, so temperature and voltage drift are tracked without disturbing live transfers. All slave settings change together in a single cycle. A sweep that is cut short by the window closing leaves the slaves untouched and continues from where it stopped in the next window. The delay-element type is chosen through a select input that is latched when a fresh sweep starts and passed to the slaves together with their taps. The block only observes the clock and never drives one.

Top module: `dll_delay_ctrl`

## Requirements
- R1: After synchronous reset, master_taps, master_sel, slave_sel, every rd_taps lane, wr_taps and locked are all zero.
- R2: When a window opens with no interrupted sweep pending, master_taps restarts at 0 and master_sel takes elem_sel on the first clock. master_taps then rises by exactly 1 on each clock where pd_late is low.
- R3: On the first clock in a window where pd_late is high, with N = master_taps, every lane updates in that same clock. Lane i of rd_taps (bits i*8 upward) is set to min(N, (N*frac_rd[i*8 +: 8])>>8), and wr_taps is set to min(N, (N*frac_wr)>>8). slave_sel takes master_sel.
- R4: locked rises on the first completed calibration and then stays high.
- R5: rd_taps, wr_taps, slave_sel, locked and master_taps change only on clocks where refresh_win is high.
- R6: If the window closes during a sweep, the slave settings are kept and master_taps holds its value. The next window continues from that held value without reloading master_sel.
- R7: If master_taps reaches its maximum (255) without alignment, it wraps to 0 and the sweep goes on, with no slave update.
- R8: Changes to frac_rd, frac_wr or elem_sel while no calibration completes leave every output unchanged.
- R9: Each new window recalibrates, so a change in element delay produces new master and slave counts.
- R10: After a calibration completes, master_taps stays at N for the rest of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_win | input | 1 | High while a DRAM refresh window is open |
| pd_late | input | 1 | Phase detector: delayed edge has reached the next reference edge |
| elem_sel | input | 2 | Delay-element type select |
| frac_rd | input | 16 | Per-read-lane fraction, 8 bits per lane, lane 0 in the low byte |
| frac_wr | input | 8 | Write-data fraction in 1/256 cycle |
| master_taps | output | 8 | Tap count driven into the master line |
| master_sel | output | 2 | Element type used by the master line |
| slave_sel | output | 2 | Element type used by the slave lines |
| rd_taps | output | 16 | Per-read-lane slave taps, 8 bits per lane |
| wr_taps | output | 8 | Write-data slave taps |
| locked | output | 1 | A calibration has completed |

## Verification
Checks run on every clock for these properties: slave settings, lock and the master count move only inside refresh windows; the master count only steps by one, wraps to zero, or holds; lock never falls; the write tap never exceeds the master count when it updates; and the master select changes only when the count is zero. The bench models the master line with a settable element delay. Its scenarios cover the things a property cannot show. These are the exact scaled tap values for several fraction patterns, the resumed count after an interrupted window, recalibration after drift, and the absence of any slave update when no alignment is ever found.

// File: rtl/dll_pkg.sv
package dll_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE  = 2'd0,
    CAL_SWEEP = 2'd1,
    CAL_HOLD  = 2'd2
  } cal_state_t;

  // Scale a per-cycle tap count by a fraction in 1/2**FW units, clamped to the count.
  function automatic logic [15:0] scale_taps(input logic [7:0] cnt, input logic [7:0] frac);
    logic [15:0] prod;
    prod = 16'(cnt) * 16'(frac);
    prod = prod >> 8;
    if (prod > 16'(cnt)) prod = 16'(cnt);
    return prod;
  endfunction

endpackage

// File: rtl/dll_cal_fsm.sv
module dll_cal_fsm
  import dll_pkg::*;
#(
  parameter int TAP_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refresh_win,
  input  logic             pd_late,
  input  logic [SEL_W-1:0] elem_sel,
  output logic [TAP_W-1:0] taps_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             apply
);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  cal_state_t st_q;
  logic       resume_q;

  assign apply = (st_q == CAL_SWEEP) && refresh_win && pd_late;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= CAL_IDLE;
      taps_q   <= '0;
      sel_q    <= '0;
      resume_q <= 1'b0;
    end else begin
      case (st_q)
        CAL_IDLE: begin
          if (refresh_win) begin
            st_q <= CAL_SWEEP;
            if (!resume_q) begin
              taps_q <= '0;
              sel_q  <= elem_sel;
            end
          end
        end
        CAL_SWEEP: begin
          if (!refresh_win) begin
            st_q     <= CAL_IDLE;
            resume_q <= 1'b1;
          end else if (pd_late) begin
            st_q     <= CAL_HOLD;
            resume_q <= 1'b0;
          end else if (taps_q == TAP_MAX) begin
            taps_q <= '0;
          end else begin
            taps_q <= taps_q + 1'b1;
          end
        end
        CAL_HOLD: begin
          if (!refresh_win) st_q <= CAL_IDLE;
        end
        default: st_q <= CAL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dll_tap_scale.sv
module dll_tap_scale
  import dll_pkg::*;
#(
  parameter int TAP_W  = 8,
  parameter int FRAC_W = 8,
  parameter int LANES  = 3
) (
  input  logic [TAP_W-1:0]        cnt,
  input  logic [LANES*FRAC_W-1:0] frac,
  output logic [LANES*TAP_W-1:0]  taps
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [15:0] full;
    always_comb begin
      full = scale_taps(8'(cnt), 8'(frac[g*FRAC_W +: FRAC_W]));
      taps[g*TAP_W +: TAP_W] = TAP_W'(full);
    end
  end
endmodule

// File: rtl/dll_slave_regs.sv
module dll_slave_regs #(
  parameter int TAP_W = 8,
  parameter int SEL_W = 2,
  parameter int LANES = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   apply,
  input  logic [LANES*TAP_W-1:0] taps_d,
  input  logic [SEL_W-1:0]       sel_d,
  output logic [LANES*TAP_W-1:0] taps_q,
  output logic [SEL_W-1:0]       sel_q,
  output logic                   locked_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q   <= '0;
      sel_q    <= '0;
      locked_q <= 1'b0;
    end else if (apply) begin
      taps_q   <= taps_d;
      sel_q    <= sel_d;
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dll_delay_ctrl.sv
module dll_delay_ctrl #(
  parameter int TAP_W  = 8,
  parameter int FRAC_W = 8,
  parameter int SEL_W  = 2,
  parameter int NUM_RD = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     refresh_win,
  input  logic                     pd_late,
  input  logic [SEL_W-1:0]         elem_sel,
  input  logic [NUM_RD*FRAC_W-1:0] frac_rd,
  input  logic [FRAC_W-1:0]        frac_wr,
  output logic [TAP_W-1:0]         master_taps,
  output logic [SEL_W-1:0]         master_sel,
  output logic [SEL_W-1:0]         slave_sel,
  output logic [NUM_RD*TAP_W-1:0]  rd_taps,
  output logic [TAP_W-1:0]         wr_taps,
  output logic                     locked
);
  localparam int LANES = NUM_RD + 1;

  logic                   apply;
  logic [LANES*FRAC_W-1:0] frac_all;
  logic [LANES*TAP_W-1:0]  taps_next;
  logic [LANES*TAP_W-1:0]  taps_cur;

  assign frac_all = {frac_wr, frac_rd};

  dll_cal_fsm #(.TAP_W(TAP_W), .SEL_W(SEL_W)) cal_i (
    .clk(clk), .rst(rst), .refresh_win(refresh_win), .pd_late(pd_late),
    .elem_sel(elem_sel), .taps_q(master_taps), .sel_q(master_sel), .apply(apply)
  );

  dll_tap_scale #(.TAP_W(TAP_W), .FRAC_W(FRAC_W), .LANES(LANES)) scale_i (
    .cnt(master_taps), .frac(frac_all), .taps(taps_next)
  );

  dll_slave_regs #(.TAP_W(TAP_W), .SEL_W(SEL_W), .LANES(LANES)) slv_i (
    .clk(clk), .rst(rst), .apply(apply), .taps_d(taps_next), .sel_d(master_sel),
    .taps_q(taps_cur), .sel_q(slave_sel), .locked_q(locked)
  );

  assign rd_taps = taps_cur[NUM_RD*TAP_W-1:0];
  assign wr_taps = taps_cur[LANES*TAP_W-1 -: TAP_W];
endmodule

// File: rtl/dll_delay_ctrl_chk.sv
module dll_delay_ctrl_chk #(
  parameter int TAP_W  = 8,
  parameter int SEL_W  = 2,
  parameter int NUM_RD = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    refresh_win,
  input logic [TAP_W-1:0]        master_taps,
  input logic [SEL_W-1:0]        master_sel,
  input logic [SEL_W-1:0]        slave_sel,
  input logic [NUM_RD*TAP_W-1:0] rd_taps,
  input logic [TAP_W-1:0]        wr_taps,
  input logic                    locked
);
  a_r5_slaves_in_window: assert property (@(posedge clk) disable iff (rst)
    !$stable({rd_taps, wr_taps, slave_sel}) |-> $past(refresh_win));

  a_r5_master_in_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(master_taps) |-> $past(refresh_win));

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> locked);

  a_r4_lock_in_window: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(refresh_win));

  // R2 and R7: the count steps by one, restarts at zero, or holds
  a_r2_master_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(master_taps) |-> (master_taps == TAP_W'($past(master_taps) + 1'b1)) || (master_taps == '0));

  a_r2_sel_at_restart: assert property (@(posedge clk) disable iff (rst)
    !$stable(master_sel) |-> master_taps == '0);

  a_r3_wr_bounded: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_taps) |-> wr_taps <= master_taps);
endmodule

bind dll_delay_ctrl dll_delay_ctrl_chk #(.TAP_W(TAP_W), .SEL_W(SEL_W), .NUM_RD(NUM_RD)) chk_i (
  .clk(clk), .rst(rst), .refresh_win(refresh_win), .master_taps(master_taps),
  .master_sel(master_sel), .slave_sel(slave_sel), .rd_taps(rd_taps),
  .wr_taps(wr_taps), .locked(locked)
);

// File: tb/dll_delay_ctrl_tb_top.sv
module dll_delay_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        refresh_win = 1'b0;
  logic        pd_late;
  logic [1:0]  elem_sel = 2'd0;
  logic [15:0] frac_rd = '0;
  logic [7:0]  frac_wr = '0;
  logic [7:0]  master_taps;
  logic [1:0]  master_sel, slave_sel;
  logic [15:0] rd_taps;
  logic [7:0]  wr_taps;
  logic        locked;

  int n_chk = 0;
  int n_bad = 0;
  int drift = 0;
  localparam int PERIOD = 8000;

  always #4 clk = ~clk;

  // Behavioural master line: element delay depends on the latched type plus drift
  function automatic int elem_delay(input logic [1:0] s);
    return 50 * (int'(s) + 1) + drift;
  endfunction
  assign pd_late = (int'(master_taps) * elem_delay(master_sel)) >= PERIOD;

  dll_delay_ctrl dut_i (
    .clk(clk), .rst(rst), .refresh_win(refresh_win), .pd_late(pd_late),
    .elem_sel(elem_sel), .frac_rd(frac_rd), .frac_wr(frac_wr),
    .master_taps(master_taps), .master_sel(master_sel), .slave_sel(slave_sel),
    .rd_taps(rd_taps), .wr_taps(wr_taps), .locked(locked)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input int d);
    return (PERIOD + d - 1) / d;
  endfunction

  function automatic int exp_tap(input int n, input int f);
    int t;
    t = (n * f) >> 8;
    return (t > n) ? n : t;
  endfunction

  task automatic check_slaves(input string req, input int n, input int s);
    check({req, " rd0"}, int'(rd_taps[7:0]),  exp_tap(n, int'(frac_rd[7:0])));
    check({req, " rd1"}, int'(rd_taps[15:8]), exp_tap(n, int'(frac_rd[15:8])));
    check({req, " wr"},  int'(wr_taps),       exp_tap(n, int'(frac_wr)));
    check({req, " slave_sel"}, int'(slave_sel), s);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    check("R1 master_taps", int'(master_taps), 0);
    check("R1 master_sel", int'(master_sel), 0);
    check("R1 slave_sel", int'(slave_sel), 0);
    check("R1 rd_taps", int'(rd_taps), 0);
    check("R1 wr_taps", int'(wr_taps), 0);
    check("R1 locked", int'(locked), 0);
  endtask

  task automatic t_first_lock();
    int n;
    elem_sel = 2'd0; drift = 0;
    frac_rd = {8'd255, 8'd64}; frac_wr = 8'd128;
    n = exp_count(50);
    refresh_win = 1'b1;
    step(1);
    check("R2 start count", int'(master_taps), 0);
    check("R2 sel latched", int'(master_sel), 0);
    step(1);
    check("R2 step1", int'(master_taps), 1);
    step(1);
    check("R2 step2", int'(master_taps), 2);
    step(n + 20);
    check("R10 count held", int'(master_taps), n);
    check("R4 locked", int'(locked), 1);
    check_slaves("R3 first", n, 0);
    refresh_win = 1'b0;
    step(3);
  endtask

  task automatic t_ignore_then_select();
    int n;
    logic [15:0] rd0;
    logic [7:0] wr0, m0;
    rd0 = rd_taps; wr0 = wr_taps; m0 = master_taps;
    frac_rd = {8'd32, 8'd200}; frac_wr = 8'd10; elem_sel = 2'd1;
    step(10);
    check("R8 rd unchanged", int'(rd_taps), int'(rd0));
    check("R8 wr unchanged", int'(wr_taps), int'(wr0));
    check("R8 master unchanged", int'(master_taps), int'(m0));
    check("R8 master_sel unchanged", int'(master_sel), 0);
    n = exp_count(100);
    refresh_win = 1'b1;
    step(n + 20);
    refresh_win = 1'b0;
    step(2);
    check("R9 sel1 count", int'(master_taps), n);
    check_slaves("R3 sel1", n, 1);
  endtask

  task automatic t_drift();
    int n;
    elem_sel = 2'd0; drift = 14;
    frac_rd = {8'd128, 8'd0}; frac_wr = 8'd255;
    n = exp_count(64);
    refresh_win = 1'b1;
    step(n + 20);
    refresh_win = 1'b0;
    step(2);
    check("R9 drift count", int'(master_taps), n);
    check_slaves("R9 drift", n, 0);
  endtask

  task automatic t_abort_resume();
    int n;
    logic [15:0] rd0;
    logic [7:0] wr0;
    drift = -10; elem_sel = 2'd0;
    frac_rd = {8'd100, 8'd150}; frac_wr = 8'd77;
    rd0 = rd_taps; wr0 = wr_taps;
    n = exp_count(40);
    refresh_win = 1'b1;
    step(30);
    refresh_win = 1'b0;
    step(1);
    check("R6 held count", int'(master_taps), 29);
    step(5);
    check("R6 rd kept", int'(rd_taps), int'(rd0));
    check("R6 wr kept", int'(wr_taps), int'(wr0));
    elem_sel = 2'd2;
    refresh_win = 1'b1;
    step(1);
    check("R6 resume no restart", int'(master_taps), 29);
    check("R6 sel kept", int'(master_sel), 0);
    step(1);
    check("R6 resume step", int'(master_taps), 30);
    step(n);
    refresh_win = 1'b0;
    step(2);
    check("R6 final count", int'(master_taps), n);
    check_slaves("R6 final", n, 0);
  endtask

  task automatic t_no_align();
    logic [15:0] rd0;
    logic [7:0] wr0;
    bit saw_max, saw_wrap;
    drift = -30; elem_sel = 2'd0;
    rd0 = rd_taps; wr0 = wr_taps;
    saw_max = 0; saw_wrap = 0;
    refresh_win = 1'b1;
    step(1);
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (master_taps == 8'd255) saw_max = 1;
      else if (saw_max && master_taps == 8'd0) saw_wrap = 1;
    end
    refresh_win = 1'b0;
    step(2);
    check("R7 wrapped", int'(saw_wrap), 1);
    check("R7 rd unchanged", int'(rd_taps), int'(rd0));
    check("R7 wr unchanged", int'(wr_taps), int'(wr0));
    check("R4 lock kept", int'(locked), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_lock();
        t_ignore_then_select();
        t_drift();
        t_abort_resume();
        t_no_align();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule